// File: doc/BRIEF.md
# Addressable Eight-Bit Latch

This block holds eight single-bit values that are written one at a time. A single data bit, a binary address and two active-low controls, a write enable and a clear, are shared by all eight storage bits. While the enable is asserted, the bit chosen by the address is transparent and follows the data input. When the enable is released, that bit keeps the last value it saw. The other seven bits are never disturbed by a write.

The enable and the clear are decoded together into four operating modes. The first is addressable write, with enable low and clear high. The second is hold, with both high. The third is one-of-eight decode, with both low: only the addressed output carries the data bit and all other outputs are low. The fourth is clear-all, with enable high and clear low. Storage is level-sensitive, so every mode acts while its inputs are held, without a clock.

The stored bits appear together as one parallel output bus. The address must stay stable while the enable is low. Stored values are undefined until the first clear or write.

Top module: `addressable_latch`

## Requirements
- R1: The address is binary with `sel_addr[0]` as the least significant bit, and address value k selects output bit `q_bits[k]`.
- R2: With `wr_en_n`=0 and `clr_n`=1, the addressed output is transparent and follows `din` while the enable stays low.
- R3: On the rising edge of `wr_en_n` with `clr_n`=1, the addressed bit keeps the `din` value present at that edge and holds it while `din` changes afterwards.
- R4: In addressable write mode, every output whose index differs from the address keeps its previous value.
- R5: With `wr_en_n`=1 and `clr_n`=1, all outputs hold their state whatever `din` and `sel_addr` do.
- R6: With `wr_en_n`=1 and `clr_n`=0, all outputs are low.
- R7: With `wr_en_n`=0 and `clr_n`=0, `q_bits` equals `din` shifted left by `sel_addr`: the addressed output follows `din` and every other output is low.
- R8: The clear is level-sensitive. After `clr_n` returns high with the enable high, all outputs stay low until a later write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 1 | Data bit written to the addressed output |
| sel_addr | input | ADDR_W | Binary index of the target bit |
| wr_en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low level clear |
| q_bits | output | 2**ADDR_W | Parallel bus of all stored bits |

## Verification
The bench builds the block with its default `ADDR_W` of 3, which gives eight storage bits. At that size, every address can be written with both data values in every one of the four modes. After each single input change, the bench compares all eight outputs at once against an arithmetic model. This makes disturbance of unaddressed bits, capture at the enable edge, and decode shifting by every address all directly observable.

// File: rtl/adl_pkg.sv
package adl_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DECODE = 2'd2,
        MODE_CLEAR = 2'd3
    } adl_mode_e;

    typedef struct packed {
        logic open;
        logic val;
    } cell_next_t;

endpackage

// File: rtl/adl_mode_dec.sv
module adl_mode_dec
    import adl_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      clr_n,
    output adl_mode_e mode
);
    always_comb begin
        unique case ({clr_n, wr_en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DECODE;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/adl_addr_dec.sv
module adl_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      sel
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            sel[i] = (addr == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/adl_cell.sv
module adl_cell
    import adl_pkg::*;
(
    input  cell_next_t nxt_d,
    output logic       bit_q
);
    always_latch begin
        if (nxt_d.open) begin
            bit_q <= nxt_d.val;
        end
    end
endmodule

// File: rtl/addressable_latch.sv
module addressable_latch
    import adl_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N = 1 << ADDR_W
) (
    input  logic              din,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              wr_en_n,
    input  logic              clr_n,
    output logic [N-1:0]      q_bits
);
    adl_mode_e          mode;
    logic [N-1:0]       sel;
    cell_next_t [N-1:0] nxt_d;
    logic [N-1:0]       bits_q;

    adl_mode_dec i_mode_dec (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .mode    (mode)
    );

    adl_addr_dec #(.ADDR_W(ADDR_W)) i_addr_dec (
        .addr (sel_addr),
        .sel  (sel)
    );

    // Next-value decision per bit: open the latch and pick the value.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            nxt_d[i].open = 1'b0;
            nxt_d[i].val  = 1'b0;
            unique case (mode)
                MODE_WRITE: begin
                    nxt_d[i].open = sel[i];
                    nxt_d[i].val  = din;
                end
                MODE_HOLD: begin
                    nxt_d[i].open = 1'b0;
                end
                MODE_DECODE: begin
                    nxt_d[i].open = 1'b1;
                    nxt_d[i].val  = sel[i] & din;
                end
                MODE_CLEAR: begin
                    nxt_d[i].open = 1'b1;
                    nxt_d[i].val  = 1'b0;
                end
            endcase
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cell
        adl_cell i_cell (
            .nxt_d (nxt_d[g]),
            .bit_q (bits_q[g])
        );
    end

    assign q_bits = bits_q;

    // Before the enable rises in write mode, the addressed bit shows din.
    assert_capture_R3: assert property (
        @(posedge wr_en_n) disable iff (!clr_n) q_bits[sel_addr] == din);

    // Leaving clear-all: all outputs were low.
    assert_clear_all_R6: assert property (
        @(posedge clr_n) wr_en_n |-> q_bits == '0);

    // Leaving decode mode via clr_n: output was din at the addressed bit only.
    assert_decode_clr_R7: assert property (
        @(posedge clr_n) !wr_en_n |-> q_bits == ({{(N-1){1'b0}}, din} << sel_addr));

    // Leaving decode mode via enable: same shape.
    assert_decode_en_R7: assert property (
        @(posedge wr_en_n) !clr_n |-> q_bits == ({{(N-1){1'b0}}, din} << sel_addr));

endmodule

// File: tb/test_addressable_latch.sv
module test_addressable_latch;
    localparam int ADDR_W = 3;
    localparam int N = 1 << ADDR_W;

    logic clk = 1'b0;
    logic din = 1'b0;
    logic [ADDR_W-1:0] sel_addr = '0;
    logic wr_en_n = 1'b1;
    logic clr_n = 1'b0;
    logic [N-1:0] q_bits;

    logic [N-1:0] model = '0;
    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    addressable_latch #(.ADDR_W(ADDR_W)) i_addressable_latch (
        .din      (din),
        .sel_addr (sel_addr),
        .wr_en_n  (wr_en_n),
        .clr_n    (clr_n),
        .q_bits   (q_bits)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Model update derived from the requirements.
    task automatic update_model();
        for (int i = 0; i < N; i++) begin
            if (!clr_n)
                model[i] = (!wr_en_n && i == int'(sel_addr)) ? din : 1'b0;
            else if (!wr_en_n && i == int'(sel_addr))
                model[i] = din;
        end
    endtask

    task automatic step_check(input string req);
        #1;
        update_model();
        #2;
        n_checks++;
        if (q_bits !== model) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, q_bits, model);
        end
    endtask

    initial begin
        // Reset state via clear (R6)
        #3;
        step_check("R6 initial clear");
        clr_n = 1'b1;
        step_check("R8 clear released stays low");
        din = 1'b1;
        step_check("R8 din change after clear");

        // Addressable write sweep: R1 R2 R3 R4
        for (int pat = 0; pat < 4; pat++) begin
            logic [N-1:0] p;
            p = (pat == 0) ? 8'hA5 : (pat == 1) ? 8'h5A : (pat == 2) ? 8'hFF : 8'h00;
            for (int a = 0; a < N; a++) begin
                sel_addr = ADDR_W'(a);
                step_check("R5 addr change while disabled");
                din = ~p[a];
                step_check("R5 din change while disabled");
                wr_en_n = 1'b0;
                step_check("R1 R2 R4 transparent write");
                din = p[a];
                step_check("R2 follows din");
                wr_en_n = 1'b1;
                step_check("R3 capture at rising enable");
                din = ~p[a];
                step_check("R3 held after din change");
            end
            n_checks++;
            if (q_bits !== p) begin
                n_fail++;
                $display("FAIL R1 R4 pattern: actual %b expected %b", q_bits, p);
            end
        end

        // Load 0xC3 then sweep hold mode inputs (R5)
        for (int a = 0; a < N; a++) begin
            logic [7:0] v;
            v = 8'hC3;
            sel_addr = ADDR_W'(a);
            din = v[a];
            step_check("R5 setup");
            wr_en_n = 1'b0;
            step_check("R2 load");
            wr_en_n = 1'b1;
            step_check("R3 load");
        end
        for (int a = 0; a < N; a++) begin
            for (int d = 0; d < 2; d++) begin
                sel_addr = ADDR_W'(N - 1 - a);
                din = d[0];
                step_check("R5 hold sweep");
            end
        end

        // Decode and clear modes (R6 R7)
        clr_n = 1'b0;
        step_check("R6 clear all");
        for (int a = 0; a < N; a++) begin
            for (int d = 0; d < 2; d++) begin
                sel_addr = ADDR_W'(a);
                din = d[0];
                step_check("R6 clear while addr changes");
                wr_en_n = 1'b0;
                step_check("R7 decode");
                n_checks++;
                if (q_bits !== (N'(d) << a)) begin
                    n_fail++;
                    $display("FAIL R7 shift: actual %b expected %b", q_bits, N'(d) << a);
                end
                din = ~din;
                step_check("R7 decode follows din");
                wr_en_n = 1'b1;
                step_check("R6 back to clear");
            end
        end
        clr_n = 1'b1;
        step_check("R8 release after clear");
        din = 1'b1;
        sel_addr = 3'd5;
        step_check("R8 still low");
        wr_en_n = 1'b0;
        step_check("R2 write after clear");
        wr_en_n = 1'b1;
        step_check("R3 capture after clear");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule